// File: doc/BRIEF.md
# Display Transmitter Interrupt Status Unit

This unit collects events from a display link transmitter core and holds them in two 8-bit sticky interrupt registers. The event sources are three asynchronous line inputs (hot-plug detect, receiver sense and vertical sync), the 4-bit state code of a link-authentication controller, and three single-cycle pulses from that controller. The pulses report that EDID data is ready, that the downstream key list has been read, and that the controller has hit an error. Each flag has its own trigger rule. Some flags fire on a rising edge, some on either edge, and one fires only on one particular state-to-state step of the controller.

Software reaches the unit through a small synchronous register port. A write of one clears a flag. Each interrupt register has an 8-bit enable register. A live status register shows the synchronized line levels, and a read-only field shows the controller state. One registered, active-high interrupt line carries the OR of every enabled flag.

Top module: `tx_irq_status`

## Requirements
- R1: After reset both flag registers, both enable registers and the interrupt output are zero. The register map has flags A at address 0, flags B at address 1, enables A at address 2, enables B at address 3, line status at address 4 and controller state at address 5.
- R2: Every flag stays at 1 until software writes a 1 to its bit position. Writing a 0 to a bit leaves that flag unchanged.
- R3: Flags A bit 1 is set only when the controller state steps from 3 directly to 4. No other step sets it.
- R4: Flags A bit 2 is set by an EDID-ready pulse.
- R5: Flags A bit 5 is set by a rising edge of vertical sync. A falling edge does not set it.
- R6: Flags A bit 6 is set by a change of receiver sense in either direction.
- R7: Flags A bit 7 is set by a change of hot-plug detect in either direction.
- R8: Flags B bit 6 is set by a key-list-read pulse. Flags B bit 7 is set by a controller-error pulse.
- R9: The three line inputs each pass through a two-stage synchronizer. Address 4 reads the synchronized hot-plug level in bit 6 and the synchronized receiver-sense level in bit 5, with all other bits 0. Address 5 reads the controller state in bits 3:0, with the upper bits 0.
- R10: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up at 1.
- R11: The interrupt output equals the OR over both registers of each flag ANDed with its enable bit, delayed by one clock.
- R12: Flag bit positions that have no source always read 0 and ignore writes. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_line | input | 1 | Hot-plug detect, asynchronous |
| rxsense_line | input | 1 | Receiver-sense comparator output, asynchronous |
| vsync_line | input | 1 | Vertical sync, asynchronous |
| auth_state | input | 4 | Authentication controller state code, synchronous |
| edid_ready_pulse | input | 1 | One-cycle pulse: EDID available |
| keys_read_pulse | input | 1 | One-cycle pulse: key list read |
| auth_err_pulse | input | 1 | One-cycle pulse: controller error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data (ones clear flags) |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Registered combined interrupt |

## Verification
The random phase draws one event at a time: a hot-plug or receiver-sense toggle in either direction, a vertical sync toggle, one of the three pulses, or a pair of controller state steps weighted toward 3-to-4. After each draw both flag registers are read in full. This separates edge-polarity rules (the vertical sync falling edge must leave no flag) from either-edge rules, and shows that steps such as 4-to-3 or 2-to-4 do not set bit 1. Random enable masks then test the interrupt OR against the flags now held. Directed cases cover a set and a clear in the same cycle, writes of zero, and reads of unmapped addresses and unused bits.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    // register map
    localparam logic [ADDR_W-1:0] ADR_FLAGS_A = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FLAGS_B = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ENA_A   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ENA_B   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_LINES   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STATE   = 3'd5;

    // flag bit positions in register A
    localparam int BA_AUTH  = 1;
    localparam int BA_EDID  = 2;
    localparam int BA_VSYNC = 5;
    localparam int BA_RXS   = 6;
    localparam int BA_HPD   = 7;
    // flag bit positions in register B
    localparam int BB_KEYS  = 6;
    localparam int BB_ERR   = 7;
    // line status bit positions
    localparam int BL_HPD   = 6;
    localparam int BL_RXS   = 5;

    localparam logic [REG_W-1:0] MASK_A =
        REG_W'((1 << BA_AUTH) | (1 << BA_EDID) | (1 << BA_VSYNC) | (1 << BA_RXS) | (1 << BA_HPD));
    localparam logic [REG_W-1:0] MASK_B =
        REG_W'((1 << BB_KEYS) | (1 << BB_ERR));

    typedef struct packed {
        logic auth;
        logic edid;
        logic vsync;
        logic rxs;
        logic hpd;
        logic keys;
        logic err;
    } evt_t;

endpackage

// File: rtl/tx_irq_sync.sv
module tx_irq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];

endmodule

// File: rtl/tx_irq_event.sv
module tx_irq_event
    import tx_irq_pkg::*;
#(
    parameter int STATE_W   = 4,
    parameter int AUTH_FROM = 3,
    parameter int AUTH_TO   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hpd_s,
    input  logic               rxs_s,
    input  logic               vs_s,
    input  logic [STATE_W-1:0] state_i,
    input  logic               edid_p,
    input  logic               keys_p,
    input  logic               err_p,
    output evt_t               evt_o
);

    localparam logic [STATE_W-1:0] ST_FROM = STATE_W'(AUTH_FROM);
    localparam logic [STATE_W-1:0] ST_TO   = STATE_W'(AUTH_TO);

    typedef struct packed {
        logic               hpd;
        logic               rxs;
        logic               vs;
        logic [STATE_W-1:0] state;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.hpd   = hpd_s;
        prev_d.rxs   = rxs_s;
        prev_d.vs    = vs_s;
        prev_d.state = state_i;

        evt_o.hpd   = hpd_s ^ prev_q.hpd;
        evt_o.rxs   = rxs_s ^ prev_q.rxs;
        evt_o.vsync = vs_s & ~prev_q.vs;
        evt_o.auth  = (prev_q.state == ST_FROM) && (state_i == ST_TO);
        evt_o.edid  = edid_p;
        evt_o.keys  = keys_p;
        evt_o.err   = err_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R5: a vsync event only while the synchronized level is high
    a_r5_vsync_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.vsync |-> vs_s);

    // R3: the auth event needs the state to be 4 now and to have been 3 one cycle earlier
    a_r3_auth_step: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.auth |-> (state_i == ST_TO) && ($past(state_i) == ST_FROM));

    // R7: no hot-plug event while the synchronized level holds
    a_r7_hpd_change: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(hpd_s) && $past(rst_n) |-> !evt_o.hpd);

endmodule

// File: rtl/tx_irq_regs.sv
module tx_irq_regs
    import tx_irq_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  evt_t               evt_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic               hpd_s,
    input  logic               rxs_s,
    input  logic [STATE_W-1:0] state_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [REG_W-1:0] flags_a;
        logic [REG_W-1:0] flags_b;
        logic [REG_W-1:0] ena_a;
        logic [REG_W-1:0] ena_b;
        logic             irq;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [REG_W-1:0] set_a, set_b, clr_a, clr_b;

    always_comb begin
        set_a = '0;
        set_a[BA_AUTH]  = evt_i.auth;
        set_a[BA_EDID]  = evt_i.edid;
        set_a[BA_VSYNC] = evt_i.vsync;
        set_a[BA_RXS]   = evt_i.rxs;
        set_a[BA_HPD]   = evt_i.hpd;
        set_b = '0;
        set_b[BB_KEYS]  = evt_i.keys;
        set_b[BB_ERR]   = evt_i.err;

        clr_a = (wr_i && addr_i == ADR_FLAGS_A) ? wdata_i : '0;
        clr_b = (wr_i && addr_i == ADR_FLAGS_B) ? wdata_i : '0;

        bank_d = bank_q;
        // set has priority over clear
        bank_d.flags_a = ((bank_q.flags_a & ~clr_a) | set_a) & MASK_A;
        bank_d.flags_b = ((bank_q.flags_b & ~clr_b) | set_b) & MASK_B;
        if (wr_i && addr_i == ADR_ENA_A) bank_d.ena_a = wdata_i;
        if (wr_i && addr_i == ADR_ENA_B) bank_d.ena_b = wdata_i;
        bank_d.irq = |(bank_q.flags_a & bank_q.ena_a) | |(bank_q.flags_b & bank_q.ena_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_FLAGS_A: rdata_o = bank_q.flags_a;
            ADR_FLAGS_B: rdata_o = bank_q.flags_b;
            ADR_ENA_A:   rdata_o = bank_q.ena_a;
            ADR_ENA_B:   rdata_o = bank_q.ena_b;
            ADR_LINES: begin
                rdata_o[BL_HPD] = hpd_s;
                rdata_o[BL_RXS] = rxs_s;
            end
            ADR_STATE:   rdata_o[STATE_W-1:0] = state_i;
            default:     rdata_o = '0;
        endcase
    end

    assign irq_o = bank_q.irq;

    // R2: with no write to flags A, no set flag drops
    a_r2_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADR_FLAGS_A) |=>
        ((bank_q.flags_a & $past(bank_q.flags_a)) == $past(bank_q.flags_a)));

    // R10: an event lands in its flag even under a same-cycle clear
    a_r10_set_wins_a: assert property (@(posedge clk) disable iff (!rst_n)
        (set_a != '0) |=> ((bank_q.flags_a & $past(set_a)) == $past(set_a)));

    a_r10_set_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
        (set_b != '0) |=> ((bank_q.flags_b & $past(set_b)) == $past(set_b)));

    // R11: no pending flag means the interrupt is low on the next cycle
    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.flags_a == '0 && bank_q.flags_b == '0) |=> !irq_o);

endmodule

// File: rtl/tx_irq_status.sv
module tx_irq_status
    import tx_irq_pkg::*;
#(
    parameter int STATE_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AUTH_FROM   = 3,
    parameter int AUTH_TO     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hpd_line,
    input  logic               rxsense_line,
    input  logic               vsync_line,
    input  logic [STATE_W-1:0] auth_state,
    input  logic               edid_ready_pulse,
    input  logic               keys_read_pulse,
    input  logic               auth_err_pulse,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq
);

    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lines_s;
    evt_t               evt;

    tx_irq_sync #(
        .W      (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hpd_line, rxsense_line, vsync_line}),
        .sync_o  (lines_s)
    );

    tx_irq_event #(
        .STATE_W   (STATE_W),
        .AUTH_FROM (AUTH_FROM),
        .AUTH_TO   (AUTH_TO)
    ) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .hpd_s   (lines_s[2]),
        .rxs_s   (lines_s[1]),
        .vs_s    (lines_s[0]),
        .state_i (auth_state),
        .edid_p  (edid_ready_pulse),
        .keys_p  (keys_read_pulse),
        .err_p   (auth_err_pulse),
        .evt_o   (evt)
    );

    tx_irq_regs #(
        .STATE_W (STATE_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .hpd_s   (lines_s[2]),
        .rxs_s   (lines_s[1]),
        .state_i (auth_state),
        .rdata_o (reg_rdata),
        .irq_o   (irq)
    );

    // R9: the synchronized hot-plug level is the raw line delayed by the synchronizer
    a_r9_hpd_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rst_n, 2) |-> lines_s[2] == $past(hpd_line, SYNC_STAGES));

endmodule

// File: tb/tx_irq_status_bench.sv
module tx_irq_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hpd_line = 1'b0, rxsense_line = 1'b0, vsync_line = 1'b0;
    logic [3:0] auth_state = 4'd0;
    logic       edid_ready_pulse = 1'b0, keys_read_pulse = 1'b0, auth_err_pulse = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx_irq_status u_tx_irq_status (
        .clk(clk), .rst_n(rst_n),
        .hpd_line(hpd_line), .rxsense_line(rxsense_line), .vsync_line(vsync_line),
        .auth_state(auth_state),
        .edid_ready_pulse(edid_ready_pulse), .keys_read_pulse(keys_read_pulse),
        .auth_err_pulse(auth_err_pulse),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req, input string what);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, req, what);
    endtask

    // expected flag bits for one drawn event, from the requirements
    function automatic logic [15:0] exp_flags(input int kind, input logic new_lvl,
                                              input logic [3:0] s0, input logic [3:0] s1,
                                              input logic [3:0] s2);
        logic [7:0] a = 8'h00, b = 8'h00;
        case (kind)
            0: a[7] = 1'b1;                                    // R7 hpd any edge
            1: a[6] = 1'b1;                                    // R6 rx sense any edge
            2: a[5] = new_lvl;                                 // R5 vsync rising only
            3: a[2] = 1'b1;                                    // R4 edid
            4: b[6] = 1'b1;                                    // R8 keys
            5: b[7] = 1'b1;                                    // R8 error
            default: a[1] = (s0 == 4'd3 && s1 == 4'd4) || (s1 == 4'd3 && s2 == 4'd4); // R3
        endcase
        return {a, b};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [3:0] prev_st;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd_chk(3'd0, 8'h00, "R1", "flags A after reset");
        rd_chk(3'd1, 8'h00, "R1", "flags B after reset");
        rd_chk(3'd2, 8'h00, "R1", "enables A after reset");
        rd_chk(3'd3, 8'h00, "R1", "enables B after reset");
        check({7'd0, irq}, 8'h00, "R1", "irq after reset");

        // R2 sticky, write zero has no effect
        edid_ready_pulse = 1'b1; tick(1); edid_ready_pulse = 1'b0;
        wr(3'd0, 8'h00);
        rd_chk(3'd0, 8'h04, "R2", "flag after write of zero");
        wr(3'd0, 8'hFB);
        rd_chk(3'd0, 8'h04, "R2", "flag after clearing other bits");
        tick(10);
        rd_chk(3'd0, 8'h04, "R2", "flag held over idle cycles");
        wr(3'd0, 8'h04);
        rd_chk(3'd0, 8'h00, "R2", "flag after write one");

        // R10 set wins over a same-cycle clear
        edid_ready_pulse = 1'b1; keys_read_pulse = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h04;
        tick(1);
        edid_ready_pulse = 1'b0; keys_read_pulse = 1'b0; reg_wr = 1'b0;
        rd_chk(3'd0, 8'h04, "R10", "edid flag under clear");
        keys_read_pulse = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'hFF;
        tick(1);
        keys_read_pulse = 1'b0; reg_wr = 1'b0;
        rd_chk(3'd1, 8'h40, "R10", "keys flag under clear");
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        rd_chk(3'd0, 8'h00, "R10", "flags A cleared after");

        // R12 unused bits and unmapped addresses
        wr(3'd6, 8'hFF);
        rd_chk(3'd6, 8'h00, "R12", "address 6");
        rd_chk(3'd7, 8'h00, "R12", "address 7");
        hpd_line = 1'b1; rxsense_line = 1'b1; vsync_line = 1'b1;
        edid_ready_pulse = 1'b1; keys_read_pulse = 1'b1; auth_err_pulse = 1'b1;
        auth_state = 4'd3; tick(1);
        edid_ready_pulse = 1'b0; keys_read_pulse = 1'b0; auth_err_pulse = 1'b0;
        auth_state = 4'd4; tick(5);
        rd_chk(3'd0, 8'hE6, "R12", "flags A all sources set");
        rd_chk(3'd1, 8'hC0, "R12", "flags B all sources set");
        // R9 line status and state field
        rd_chk(3'd4, 8'h60, "R9", "line status both high");
        rd_chk(3'd5, 8'h04, "R9", "state field");
        // R11 irq with single enable bit
        wr(3'd3, 8'h80); tick(1);
        check({7'd0, irq}, 8'h01, "R11", "irq from error flag");
        wr(3'd1, 8'h80); tick(1);
        check({7'd0, irq}, 8'h00, "R11", "irq after clearing enabled flag");
        wr(3'd3, 8'h00);
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        hpd_line = 1'b0; rxsense_line = 1'b0; vsync_line = 1'b0;
        tick(5);
        wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'h00, "R2", "flags clear before random phase");
        prev_st = auth_state;

        // random phase
        for (int it = 0; it < 60; it++) begin
            int kind;
            logic [3:0] s1, s2;
            logic [7:0] e_a, e_b, en_a, en_b;
            logic [15:0] ef;
            logic nl;
            kind = $urandom_range(0, 6);
            nl = 1'b0;
            s1 = prev_st; s2 = prev_st;
            case (kind)
                0: begin hpd_line = ~hpd_line; tick(5); end
                1: begin rxsense_line = ~rxsense_line; tick(5); end
                2: begin vsync_line = ~vsync_line; nl = vsync_line; tick(5); end
                3: begin edid_ready_pulse = 1'b1; tick(1); edid_ready_pulse = 1'b0; tick(2); end
                4: begin keys_read_pulse = 1'b1; tick(1); keys_read_pulse = 1'b0; tick(2); end
                5: begin auth_err_pulse = 1'b1; tick(1); auth_err_pulse = 1'b0; tick(2); end
                default: begin
                    if ($urandom_range(0, 1) == 1) begin s1 = 4'd3; s2 = 4'd4; end
                    else begin s1 = 4'($urandom_range(0, 15)); s2 = 4'($urandom_range(0, 15)); end
                    auth_state = s1; tick(2);
                    auth_state = s2; tick(3);
                end
            endcase
            ef = exp_flags(kind, nl, prev_st, s1, s2);
            prev_st = auth_state;
            e_a = ef[15:8]; e_b = ef[7:0];
            case (kind)
                0: rd_chk(3'd0, e_a, "R7", "hpd toggle flags A");
                1: rd_chk(3'd0, e_a, "R6", "rx sense toggle flags A");
                2: rd_chk(3'd0, e_a, "R5", "vsync toggle flags A");
                3: rd_chk(3'd0, e_a, "R4", "edid pulse flags A");
                6: rd_chk(3'd0, e_a, "R3", "state steps flags A");
                default: rd_chk(3'd0, e_a, "R8", "pulse flags A");
            endcase
            rd_chk(3'd1, e_b, "R8", "flags B");
            rd_chk(3'd4, {1'b0, hpd_line, rxsense_line, 5'd0}, "R9", "line status");
            rd_chk(3'd5, {4'd0, auth_state}, "R9", "state field");
            en_a = 8'($urandom); en_b = 8'($urandom);
            wr(3'd2, en_a); wr(3'd3, en_b); tick(1);
            check({7'd0, irq}, {7'd0, (|(e_a & en_a)) | (|(e_b & en_b))}, "R11", "irq vs enables");
            wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
            rd_chk(3'd0, 8'h00, "R2", "flags A after clear");
            rd_chk(3'd1, 8'h00, "R2", "flags B after clear");
            tick(1);
            check({7'd0, irq}, 8'h00, "R11", "irq after clear");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule